// File: doc/BRIEF.md
# TDM Slot-Table Block Switch

This block is the guaranteed-throughput path of a five-port on-chip router. Time is cut into fixed slots of six clock cycles. A slot table of eight entries, walked in a fixed cycle by a free-running slot counter, names for each slot which inputs are connected and to which output each one goes. Because every pairing is reserved ahead of time, two inputs never compete for one output and no arbitration is needed.

Each input has a three-flit staging buffer. A flit is 96 bits, made of three 32-bit words. In the first three cycles of a slot, inputs accept flits over valid/ready until their buffer is full. At the end of that receive half, each input that holds a reservation in the current entry and has a complete three-flit block is selected. It then sends the whole block to its reserved output over the last three cycles. This is store-and-forward: a block leaves only once all of it is held. A block that is not complete is kept until a later reserved slot.

Reservations are installed at run time through a one-cycle write port. This port stands in for the set-up messages of the best-effort network. A write that would map two inputs to one output, or that names an output that does not exist, is refused and flagged.

Top module: `tdm_slot_switch`

## Requirements
- R1: After reset, `slot_idx` is 0, every `in_ready` bit is 1, every `out_valid` bit is 0 and `cfg_err` is 0.
- R2: A slot is 6 cycles (phases 0 to 5, phase 0 being the cycle right after reset). `slot_idx` advances by one after phase 5 and wraps from 7 to 0.
- R3: An input is ready only in phases 0 to 2, and only while its staging buffer holds fewer than 3 flits.
- R4: If an input is enabled in the current slot's entry and holds 3 flits at the end of phase 2, its flits appear in arrival order on the reserved output in phases 3, 4 and 5, one per cycle with `out_valid` high. Its buffer is then empty.
- R5: An output that no selected input maps to in the current slot keeps `out_valid` low for the whole slot.
- R6: An enabled input with fewer than 3 flits at the end of phase 2 sends nothing in that slot. The flits it holds are kept, and once they are topped up to 3 they are sent intact in a later reserved slot.
- R7: A complete block with no reservation stays buffered with `in_ready` low, and is sent the next time a slot reserves that input.
- R8: A table write uses `cfg_addr` as the entry, bit i of `cfg_en` as input i's enable, and `cfg_dst[3i+2:3i]` as input i's output index. If two enabled inputs share an output index, or an enabled index is 5 or more, the write is refused: the entry is unchanged and `cfg_err` is high for exactly the cycle after the write. A write that is accepted leaves `cfg_err` low.
- R9: The entry for a slot is sampled when that slot begins. A write to the entry of the slot in progress has no effect until that entry next comes round.
- R10: Several inputs may be connected in one slot, each to a different output. All of their blocks move in the same three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Flit offered, one bit per input |
| in_ready | output | 5 | Flit accepted this cycle when valid is high |
| in_data | input | 480 | Input flits, input i at bits [96i+95:96i] |
| out_valid | output | 5 | Flit present, one bit per output |
| out_data | output | 480 | Output flits, output o at bits [96o+95:96o] |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 3 | Table entry to write |
| cfg_en | input | 5 | Per-input connection enable for the entry |
| cfg_dst | input | 15 | Per-input output index, 3 bits each |
| cfg_err | output | 1 | Refused write, one cycle after the strobe |
| slot_idx | output | 3 | Current slot number |

## Verification
The hardest case to reach is a table write that lands in the middle of the slot whose entry it changes, while a full block is already waiting on the input it reserves. The bench fills that input during an earlier slot that has no reservation. It then issues the write during phase 0 of the target slot and checks that the slot stays idle. It then follows the counter one full round to check that the block goes out in that entry's next turn. Partial blocks are topped up across two turns of the same entry in a similar way. Beyond these, the bench sweeps every input-to-output pairing one at a time and every rotation of a full five-way permutation.

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter int NPORT = 5,
  parameter int FW    = 96,
  parameter int NSLOT = 8,
  parameter int BLK   = 3,
  localparam int DW  = $clog2(NPORT),
  localparam int SW  = $clog2(NSLOT),
  localparam int PHW = $clog2(2*BLK),
  localparam int CW  = $clog2(BLK+1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    in_valid,
  output logic [NPORT-1:0]    in_ready,
  input  logic [NPORT*FW-1:0] in_data,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*FW-1:0] out_data,
  input  logic                cfg_we,
  input  logic [SW-1:0]       cfg_addr,
  input  logic [NPORT-1:0]    cfg_en,
  input  logic [NPORT*DW-1:0] cfg_dst,
  output logic                cfg_err,
  output logic [SW-1:0]       slot_idx
);
  localparam logic [PHW-1:0] PH_RX   = PHW'(BLK);
  localparam logic [PHW-1:0] PH_DEC  = PHW'(BLK-1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(2*BLK-1);
  localparam logic [SW-1:0]  SL_LAST = SW'(NSLOT-1);
  localparam logic [CW-1:0]  FULL    = CW'(BLK);
  localparam logic [DW:0]    NP      = (DW+1)'(NPORT);

  logic [PHW-1:0] phase;
  logic [SW-1:0]  slot_q;
  logic [NPORT-1:0]    tab_en  [NSLOT];
  logic [NPORT*DW-1:0] tab_dst [NSLOT];
  logic [NPORT-1:0]    act_en;
  logic [NPORT*DW-1:0] act_dst;
  logic [NPORT-1:0]    go;
  logic [FW-1:0]       cur_flit [NPORT];
  logic                cfg_bad;

  wire rx_win = phase < PH_RX;
  wire last   = phase == PH_LAST;
  wire [PHW-1:0] emit_idx = phase - PH_RX;
  assign slot_idx = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      slot_q <= '0;
    end else if (last) begin
      phase  <= '0;
      slot_q <= (slot_q == SL_LAST) ? '0 : slot_q + SW'(1);
    end else begin
      phase <= phase + PHW'(1);
    end
  end

  always_comb begin
    cfg_bad = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (cfg_en[i] && {1'b0, cfg_dst[i*DW +: DW]} >= NP) cfg_bad = 1'b1;
      for (int j = i + 1; j < NPORT; j++)
        if (cfg_en[i] && cfg_en[j] && cfg_dst[i*DW +: DW] == cfg_dst[j*DW +: DW])
          cfg_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        tab_en[s]  <= '0;
        tab_dst[s] <= '0;
      end
      cfg_err <= 1'b0;
      act_en  <= '0;
      act_dst <= '0;
    end else begin
      cfg_err <= cfg_we && cfg_bad;
      if (cfg_we && !cfg_bad) begin
        tab_en[cfg_addr]  <= cfg_en;
        tab_dst[cfg_addr] <= cfg_dst;
      end
      if (phase == '0) begin
        act_en  <= tab_en[slot_q];
        act_dst <= tab_dst[slot_q];
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [CW-1:0] cnt;
    logic          go_r;
    logic [FW-1:0] stg [BLK];
    wire take = in_valid[i] && in_ready[i];
    wire [CW-1:0] cnt_plus = cnt + CW'(take);

    assign in_ready[i] = rx_win && (cnt != FULL);
    assign go[i]       = go_r;
    assign cur_flit[i] = stg[emit_idx];

    always_ff @(posedge clk) begin
      if (take) stg[cnt] <= in_data[i*FW +: FW];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        go_r <= 1'b0;
      end else begin
        if (take) cnt <= cnt_plus;
        if (phase == PH_DEC) go_r <= act_en[i] && (cnt_plus == FULL);
        if (last && go_r) begin
          go_r <= 1'b0;
          cnt  <= '0;
        end
      end
    end
  end

  always_comb begin
    out_valid = '0;
    out_data  = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (!rx_win && go[i] && act_dst[i*DW +: DW] == DW'(o)) begin
          out_valid[o] = 1'b1;
          out_data[o*FW +: FW] = out_data[o*FW +: FW] | cur_flit[i];
        end
  end
endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk #(
  parameter int NPORT = 5,
  parameter int NSLOT = 8,
  parameter int BLK   = 3,
  parameter int SW    = 3,
  parameter int PHW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PHW-1:0]   phase,
  input logic [SW-1:0]    slot_idx,
  input logic [NPORT-1:0] in_ready,
  input logic [NPORT-1:0] out_valid,
  input logic [NPORT-1:0] go,
  input logic             cfg_we,
  input logic             cfg_err
);
  localparam logic [PHW-1:0] PH_RX   = PHW'(BLK);
  localparam logic [PHW-1:0] PH_LAST = PHW'(2*BLK-1);
  localparam logic [SW-1:0]  SL_LAST = SW'(NSLOT-1);

  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_LAST |=> $stable(slot_idx));
  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LAST && slot_idx == SL_LAST) |=> slot_idx == '0);
  p_ready_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase >= PH_RX |-> in_ready == '0);
  p_emit_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid != '0 |-> phase >= PH_RX);
  p_select_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= PH_RX && phase != PH_LAST) |=> $stable(go));
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !cfg_err);
endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(
  .NPORT(NPORT), .NSLOT(NSLOT), .BLK(BLK), .SW(SW), .PHW(PHW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .slot_idx(slot_idx),
  .in_ready(in_ready), .out_valid(out_valid), .go(go),
  .cfg_we(cfg_we), .cfg_err(cfg_err)
);

// File: tb/tb_tdm_slot_switch.sv
module tb_tdm_slot_switch;
  localparam int NP = 5;
  localparam int FW = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP-1:0]    in_ready;
  logic [NP*FW-1:0] in_data = '0;
  logic [NP-1:0]    out_valid;
  logic [NP*FW-1:0] out_data;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [NP-1:0]    cfg_en = '0;
  logic [NP*3-1:0]  cfg_dst = '0;
  logic             cfg_err;
  logic [2:0]       slot_idx;

  tdm_slot_switch dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int phase_m = 0, slot_m = 0;
  int sent_k [NP] = '{default: 0};

  initial begin
    #(2.5 * 2 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [FW-1:0] fl(int i, int tag, int k);
    return {tag[31:0], i[31:0], k[31:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (phase_m == 5) begin
      phase_m = 0;
      slot_m = (slot_m + 1) % 8;
    end else phase_m++;
  endtask

  task automatic go_to(input int s, input int p);
    while (!(slot_m == s && phase_m == p)) tick();
  endtask

  task automatic cfg_write(input int a, input logic [NP-1:0] en,
                           input logic [NP*3-1:0] dst, output logic err);
    cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_en = en; cfg_dst = dst;
    tick();
    cfg_we = 1'b0;
    err = cfg_err;
  endtask

  // caller stands at phase 0; leaves at phase 3
  task automatic rx_phase(input logic [NP-1:0] mask, input int nfl, input int tag);
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < NP; i++) begin
        in_valid[i] = mask[i] && (c < nfl);
        in_data[i*FW +: FW] = fl(i, tag, sent_k[i]);
        if (in_valid[i]) chk(in_ready[i] == 1'b1, "R3", "ready in receive half",
                             FW'(in_ready[i]), FW'(1));
      end
      tick();
      for (int i = 0; i < NP; i++) if (in_valid[i]) sent_k[i]++;
    end
    in_valid = '0;
    chk(in_ready == '0, "R3", "ready in emit half", FW'(in_ready), FW'(0));
  endtask

  // at phase 3; leaves at phase 0 of the next slot
  task automatic tx_check(input int src [NP], input int tag);
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < NP; o++) begin
        if (src[o] >= 0) begin
          chk(out_valid[o] == 1'b1, "R4", "out_valid on reserved output",
              FW'(out_valid[o]), FW'(1));
          chk(out_data[o*FW +: FW] == fl(src[o], tag, p), "R4", "flit order/data",
              out_data[o*FW +: FW], fl(src[o], tag, p));
        end else begin
          chk(out_valid[o] == 1'b0, "R5", "idle output",
              FW'(out_valid[o]), FW'(0));
        end
      end
      tick();
    end
    for (int o = 0; o < NP; o++) if (src[o] >= 0) sent_k[src[o]] = 0;
  endtask

  initial begin
    logic e;
    int none [NP] = '{-1, -1, -1, -1, -1};
    int tag = 1;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;

    // R1
    chk(slot_idx == 3'd0, "R1", "slot after reset", FW'(slot_idx), FW'(0));
    chk(in_ready == 5'h1f, "R1", "ready after reset", FW'(in_ready), FW'(5'h1f));
    chk(out_valid == '0, "R1", "out_valid after reset", FW'(out_valid), FW'(0));
    chk(cfg_err == 1'b0, "R1", "cfg_err after reset", FW'(cfg_err), FW'(0));

    // R2: slot counter over more than one full round
    for (int n = 0; n < 60; n++) begin
      tick();
      chk(slot_idx == slot_m[2:0], "R2", "slot index", FW'(slot_idx), FW'(slot_m));
    end

    // R4/R5 sweep of all pairings through entry 0
    for (int i = 0; i < NP; i++)
      for (int d = 0; d < NP; d++) begin
        int src [NP];
        logic [NP*3-1:0] dv = '0;
        dv[i*3 +: 3] = d[2:0];
        go_to(4, 0);
        cfg_write(0, NP'(1) << i, dv, e);
        chk(e == 1'b0, "R8", "valid write accepted", FW'(e), FW'(0));
        go_to(0, 0);
        rx_phase(NP'(1) << i, 3, tag);
        src = none; src[d] = i;
        tx_check(src, tag);
        chk(in_ready[i] == 1'b1, "R4", "buffer empty after send", FW'(in_ready[i]), FW'(1));
        tag++;
      end

    // R10: every rotation of a full permutation through entry 2
    for (int r = 0; r < NP; r++) begin
      int src [NP];
      logic [NP*3-1:0] dv = '0;
      for (int i = 0; i < NP; i++) begin
        dv[i*3 +: 3] = 3'((i + r) % NP);
        src[(i + r) % NP] = i;
      end
      go_to(6, 0);
      cfg_write(2, '1, dv, e);
      chk(e == 1'b0, "R10", "permutation accepted", FW'(e), FW'(0));
      go_to(2, 0);
      rx_phase('1, 3, tag);
      tx_check(src, tag);
      tag++;
    end

    // clear entries 0 and 2
    go_to(4, 0);
    cfg_write(0, '0, '0, e);
    cfg_write(2, '0, '0, e);

    // R6: partial block on input 3 reserved to output 0 in entry 1
    cfg_write(1, 5'b01000, 15'd0, e);
    go_to(1, 0);
    rx_phase(5'b01000, 2, tag);
    tx_check(none, tag);
    go_to(1, 0);
    chk(in_ready[3] == 1'b1, "R6", "partial block kept, room left", FW'(in_ready[3]), FW'(1));
    rx_phase(5'b01000, 1, tag);
    begin
      int src [NP];
      src = none; src[0] = 3;
      tx_check(src, tag);
    end
    tag++;

    // R7: full block on input 1 with no reservation, later reserved to output 2
    go_to(4, 0);
    cfg_write(6, 5'b00010, 15'(2 << 3), e);
    go_to(5, 0);
    rx_phase(5'b00010, 3, tag);
    tx_check(none, tag);
    chk(in_ready[1] == 1'b0, "R7", "held block keeps ready low", FW'(in_ready[1]), FW'(0));
    chk(out_valid == '0, "R7", "nothing sent unreserved", FW'(out_valid), FW'(0));
    rx_phase('0, 0, tag);
    begin
      int src [NP];
      src = none; src[2] = 1;
      tx_check(src, tag);
    end
    tag++;

    // R8: refused writes leave entry 7 intact
    go_to(4, 0);
    cfg_write(7, 5'b00001, 15'd3, e);
    chk(e == 1'b0, "R8", "good write err", FW'(e), FW'(0));
    cfg_write(7, 5'b00011, 15'(4 | (4 << 3)), e);
    chk(e == 1'b1, "R8", "duplicate output refused", FW'(e), FW'(1));
    tick();
    chk(cfg_err == 1'b0, "R8", "err lasts one cycle", FW'(cfg_err), FW'(0));
    cfg_write(7, 5'b00100, 15'(5 << 6), e);
    chk(e == 1'b1, "R8", "index 5 refused", FW'(e), FW'(1));
    cfg_write(7, 5'b00011, 15'(4 | (4 << 3)) , e);
    cfg_write(7, 5'b10001, 15'(2 | (2 << 12)), e);
    chk(e == 1'b1, "R8", "duplicate across ends refused", FW'(e), FW'(1));
    go_to(7, 0);
    rx_phase(5'b00001, 3, tag);
    begin
      int src [NP];
      src = none; src[3] = 0;
      tx_check(src, tag);
    end
    tag++;

    // R9: write to running slot's entry waits a full round
    go_to(2, 0);
    rx_phase(5'b10000, 3, tag);
    tx_check(none, tag);
    chk(in_ready[4] == 1'b0, "R7", "input 4 full and held", FW'(in_ready[4]), FW'(0));
    cfg_write(3, 5'b10000, 15'(1 << 12), e);
    chk(e == 1'b0, "R9", "mid-slot write accepted", FW'(e), FW'(0));
    tick(); tick();
    tx_check(none, tag);
    go_to(3, 0);
    rx_phase('0, 0, tag);
    begin
      int src [NP];
      src = none; src[1] = 4;
      tx_check(src, tag);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule